// File: doc/BRIEF.md
# Byte-Packing Data Register

This block is the data register that sits between a register port and the byte engine of a serial bus controller. A single 32-bit store holds up to four bytes for both directions. On the register side, software writes a halfword (two bytes) or a single byte, and reads a halfword. On the bus side, the transfer sequencer takes transmit bytes one at a time, highest first, and deposits received bytes one at a time, lowest first.

A byte-order mode input decides whether a halfword crosses the register port swapped or unswapped. Writes and reads use opposite conventions. Separate transmit and receive byte counts track what the store holds. The block raises single-cycle indications for a dropped write, a read that finds one lone byte, an accepted write and any access, together with two level-ready signals, so that the surrounding status logic can maintain its flags. A transfer-start input clears the stored bytes.

Top module: `byte_pack_dreg`

## Requirements
- R1: After reset the store, `tx_count` and `rx_count` are zero, `tx_byte` and `rdata` read 0, and all pulse outputs are low.
- R2: A halfword write (`wr16`) with `tx_count` at most 2 shifts the store left by 16 bits, places the halfword in bits 15:0 and adds 2 to `tx_count`. With `swap_mode`=0, `wdata[7:0]` lands in bits 15:8 and `wdata[15:8]` in bits 7:0. With `swap_mode`=1, it is stored as written.
- R3: A byte write (`wr8`) with `tx_count` at most 2 shifts the store left by 8 bits, places `wdata[7:0]` in bits 7:0 and adds 1 to `tx_count`.
- R4: A write of either size while `tx_count` exceeds 2 leaves the store and `tx_count` unchanged and pulses `wr_drop` one cycle later. An accepted write pulses `wr_ack` one cycle later.
- R5: `tx_byte` shows store bits [8*(tx_count-1)+7 : 8*(tx_count-1)], or 0 when `tx_count` is 0. `tx_take` decrements a nonzero `tx_count` and is ignored at 0.
- R6: `rx_put` ORs `rx_byte` into the store at bit 8*`rx_count` and increments `rx_count`. It is ignored when `rx_count` is 4.
- R7: `rdata` is store bits 15:0 when `swap_mode`=0. It is {store[7:0], store[15:8]} when `swap_mode`=1.
- R8: A halfword read (`rd16`) with `rx_count`=1 clears `rx_count` and pulses `rd_underflow` one cycle later. With `rx_count`>2 it shifts the store right by 16 bits. With `rx_count`>=2 it subtracts 2. With `rx_count`=0 it changes nothing.
- R9: `tx_ready` is high exactly when `tx_count` is at most 2. `rx_ready` is high exactly when `rx_count` is nonzero.
- R10: Any `wr16`, `wr8` or `rd16`, accepted or not, pulses `kick` for one cycle, one cycle later.
- R11: `start` clears the store and keeps both counts. One action runs per cycle, in the priority start, wr16, wr8, rd16, tx_take, rx_put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_mode | input | 1 | Byte-order select for the register port |
| start | input | 1 | New transfer: clear the store |
| wr16 | input | 1 | Halfword write strobe |
| wr8 | input | 1 | Byte write strobe |
| wdata | input | 16 | Write data |
| rd16 | input | 1 | Halfword read strobe (consumes bytes) |
| rdata | output | 16 | Halfword presented for reading |
| tx_take | input | 1 | Bus side takes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| rx_put | input | 1 | Bus side deposits one received byte |
| rx_byte | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Received bytes held |
| tx_ready | output | 1 | Room for another halfword |
| rx_ready | output | 1 | Received data available |
| wr_ack | output | 1 | Pulse: a write was accepted |
| wr_drop | output | 1 | Pulse: a write was ignored (overflow) |
| rd_underflow | output | 1 | Pulse: a read found one lone byte |
| kick | output | 1 | Pulse: a data-register access occurred |

## Verification
The store and counts change at the clock edge that samples a strobe. The registered pulses `wr_ack`, `wr_drop`, `rd_underflow` and `kick` therefore appear in the cycle that follows the access. `rdata`, `tx_byte` and the ready levels are combinational from state, so they reflect an operation as soon as that edge has passed. The bench drives each strobe for exactly one edge, drops it just after the edge, and samples on the following falling edge. At that point every result of the operation is due, and the pulses have not yet returned low.

// File: rtl/byte_pack_dreg.sv
module byte_pack_dreg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swap_mode,
  input  logic        start,
  input  logic        wr16,
  input  logic        wr8,
  input  logic [15:0] wdata,
  input  logic        rd16,
  output logic [15:0] rdata,
  input  logic        tx_take,
  output logic [7:0]  tx_byte,
  input  logic        rx_put,
  input  logic [7:0]  rx_byte,
  output logic [2:0]  tx_count,
  output logic [2:0]  rx_count,
  output logic        tx_ready,
  output logic        rx_ready,
  output logic        wr_ack,
  output logic        wr_drop,
  output logic        rd_underflow,
  output logic        kick
);
  localparam int NB = 4;
  localparam int SW = NB * 8;
  localparam logic [2:0] FULL = 3'(NB);
  localparam logic [2:0] ROOM = 3'(NB - 2);

  logic [SW-1:0] store;
  logic [15:0]   half_in;
  logic [1:0]    tidx;
  logic [SW-1:0] rx_shifted;

  assign half_in    = swap_mode ? wdata : {wdata[7:0], wdata[15:8]};
  assign rdata      = swap_mode ? {store[7:0], store[15:8]} : store[15:0];
  assign tidx       = tx_count[1:0] - 2'd1;
  assign tx_byte    = (tx_count == 3'd0) ? 8'h00 : store[{tidx, 3'b000} +: 8];
  assign rx_shifted = {{(SW-8){1'b0}}, rx_byte} << {rx_count[1:0], 3'b000};
  assign tx_ready   = tx_count <= ROOM;
  assign rx_ready   = rx_count != 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store        <= '0;
      tx_count     <= '0;
      rx_count     <= '0;
      wr_ack       <= 1'b0;
      wr_drop      <= 1'b0;
      rd_underflow <= 1'b0;
      kick         <= 1'b0;
    end else begin
      kick         <= wr16 | wr8 | rd16;
      wr_ack       <= 1'b0;
      wr_drop      <= 1'b0;
      rd_underflow <= 1'b0;
      if (start) begin
        store <= '0;
      end else if (wr16 || wr8) begin
        if (tx_count > ROOM) begin
          wr_drop <= 1'b1;
        end else if (wr16) begin
          store    <= {store[SW-17:0], half_in};
          tx_count <= tx_count + 3'd2;
          wr_ack   <= 1'b1;
        end else begin
          store    <= {store[SW-9:0], wdata[7:0]};
          tx_count <= tx_count + 3'd1;
          wr_ack   <= 1'b1;
        end
      end else if (rd16) begin
        if (rx_count == 3'd1) begin
          rx_count     <= 3'd0;
          rd_underflow <= 1'b1;
        end else if (rx_count > 3'd1) begin
          if (rx_count > 3'd2) store <= store >> 16;
          rx_count <= rx_count - 3'd2;
        end
      end else if (tx_take) begin
        if (tx_count != 3'd0) tx_count <= tx_count - 3'd1;
      end else if (rx_put) begin
        if (rx_count < FULL) begin
          store    <= store | rx_shifted;
          rx_count <= rx_count + 3'd1;
        end
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (tx_count == 3'd0 && rx_count == 3'd0 && !kick && !wr_ack));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (wr16 || wr8) && tx_count > ROOM) |=> ($stable(tx_count) && wr_drop && !wr_ack));

  assert_halfword_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && wr16 && tx_count <= ROOM) |=> (tx_count == $past(tx_count) + 3'd2 && wr_ack));

  assert_counts_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= FULL && rx_count <= FULL));

  assert_lone_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr16 && !wr8 && rd16 && rx_count == 3'd1) |=> (rx_count == 3'd0 && rd_underflow));

  assert_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16 || wr8 || rd16) |=> kick);

  assert_start_keeps_counts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($stable(tx_count) && $stable(rx_count) && rdata == 16'h0000));
endmodule

// File: tb/tb_byte_pack_dreg.sv
module tb_byte_pack_dreg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap_mode = 1'b0, start = 1'b0, wr16 = 1'b0, wr8 = 1'b0, rd16 = 1'b0;
  logic tx_take = 1'b0, rx_put = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rdata;
  logic [7:0]  tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic tx_ready, rx_ready, wr_ack, wr_drop, rd_underflow, kick;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  byte_pack_dreg dut (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    start = 0; wr16 = 0; wr8 = 0; rd16 = 0; tx_take = 0; rx_put = 0;
    @(negedge clk);
  endtask

  task automatic do_wr16(input logic [15:0] d); wdata = d; wr16 = 1; step(); endtask
  task automatic do_wr8(input logic [7:0] d); wdata = {8'h00, d}; wr8 = 1; step(); endtask
  task automatic do_take(); tx_take = 1; step(); endtask
  task automatic do_put(input logic [7:0] b); rx_byte = b; rx_put = 1; step(); endtask
  task automatic do_rd(); rd16 = 1; step(); endtask
  task automatic do_start(); start = 1; step(); endtask

  task automatic t_reset();
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 tx_byte", tx_byte, 0);
    chk("R1 pulses", {wr_ack, wr_drop, rd_underflow, kick}, 0);
    chk("R9 ready at reset", {tx_ready, rx_ready}, 2'b10);
  endtask

  task automatic t_swapped_write();
    swap_mode = 0;
    do_wr16(16'h1234);
    chk("R2 count", tx_count, 2);
    chk("R2 swapped store", rdata, 16'h3412);
    chk("R4 ack", {wr_ack, wr_drop}, 2'b10);
    chk("R10 kick on write", kick, 1);
    chk("R5 first byte", tx_byte, 8'h34);
    do_take();
    chk("R5 second byte", tx_byte, 8'h12);
    chk("R5 count", tx_count, 1);
    do_take();
    chk("R5 drained", tx_count, 0);
    do_take();
    chk("R5 take at empty ignored", tx_count, 0);
    chk("R5 empty byte", tx_byte, 0);
  endtask

  task automatic t_straight_write_overflow();
    do_start();
    swap_mode = 1;
    do_wr16(16'h1234);
    chk("R2 straight first byte", tx_byte, 8'h12);
    chk("R7 swapped read view", rdata, 16'h3412);
    do_wr16(16'hABCD);
    chk("R2 count 4", tx_count, 4);
    chk("R9 tx not ready", tx_ready, 0);
    do_wr8(8'h77);
    chk("R4 drop pulse", {wr_ack, wr_drop}, 2'b01);
    chk("R4 count kept", tx_count, 4);
    chk("R4 store kept", rdata, 16'hCDAB);
    chk("R10 kick on dropped write", kick, 1);
    chk("R5 top byte", tx_byte, 8'h12); do_take();
    chk("R5 byte 2", tx_byte, 8'h34); do_take();
    chk("R5 byte 3", tx_byte, 8'hAB); do_take();
    chk("R5 byte 4", tx_byte, 8'hCD); do_take();
    chk("R5 empty", tx_count, 0);
  endtask

  task automatic t_byte_writes();
    do_start();
    swap_mode = 0;
    do_wr8(8'hAA); do_wr8(8'hBB); do_wr8(8'hCC);
    chk("R3 count", tx_count, 3);
    chk("R3 low halfword", rdata, 16'hBBCC);
    chk("R9 tx not ready at 3", tx_ready, 0);
    do_wr16(16'h5555);
    chk("R4 halfword dropped", {tx_count, wr_drop}, {3'd3, 1'b1});
    chk("R3 byte A", tx_byte, 8'hAA); do_take();
    chk("R3 byte B", tx_byte, 8'hBB); do_take();
    chk("R3 byte C", tx_byte, 8'hCC); do_take();
    chk("R9 tx ready again", tx_ready, 1);
  endtask

  task automatic t_receive();
    do_start();
    swap_mode = 0;
    do_put(8'h11); do_put(8'h22); do_put(8'h33); do_put(8'h44);
    chk("R6 count", rx_count, 4);
    chk("R9 rx ready", rx_ready, 1);
    do_put(8'h55);
    chk("R6 full ignored count", rx_count, 4);
    chk("R6 full ignored data R7", rdata, 16'h2211);
    do_rd();
    chk("R8 count after read", rx_count, 2);
    chk("R8 shifted", rdata, 16'h4433);
    chk("R10 kick on read", kick, 1);
    swap_mode = 1;
    #1 chk("R7 swapped read", rdata, 16'h3344);
    do_rd();
    chk("R8 emptied", rx_count, 0);
    chk("R9 rx not ready", rx_ready, 0);
    chk("R8 no underflow", rd_underflow, 0);
    swap_mode = 0;
  endtask

  task automatic t_underflow();
    do_start();
    do_put(8'h5A);
    chk("R6 single byte", rdata, 16'h005A);
    do_rd();
    chk("R8 underflow pulse", rd_underflow, 1);
    chk("R8 count cleared", rx_count, 0);
    do_rd();
    chk("R8 empty read no pulse", rd_underflow, 0);
    chk("R8 empty read count", rx_count, 0);
  endtask

  task automatic t_priority();
    do_wr8(8'h99);
    wdata = 16'hFFFF; wr16 = 1; start = 1; step();
    chk("R11 start wins store", rdata, 0);
    chk("R11 count kept", tx_count, 1);
    chk("R11 no ack", wr_ack, 0);
    do_take();
    chk("R11 cleared byte", tx_count, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_swapped_write();
    t_straight_write_overflow();
    t_byte_writes();
    t_receive();
    t_underflow();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule